// File: doc/BRIEF.md
# Chopped Third-Order Sinc Decimator

This block turns the one-bit output stream of a sigma-delta modulator into signed 24-bit conversion results. A third-order sinc filter is built from three running integrators and three differencing stages. The integrators run at the modulator sample rate, which is one sixteenth of the master clock. The differencing stages run once per decimation period. A 12-bit word selects the decimation factor. Changing that word moves the filter notches and leaves the shape of the response unchanged.

An optional chopping mode tells the analog front end to reverse its inputs after every result, through a polarity output. The filter is cleared after each reversal, so each chopped result covers a fresh three-period window. Each result taken in the reversed phase has its sign flipped, and the block then averages it with the result before it. The averaged stream carries no front-end offset. In both modes the block withholds results until the filter has seen a full window. Any change to the decimation word or to the mode bit restarts the filter and its settling count.

Top module: `sinc3_chop_decim`

## Requirements
- R1: Sampling. The block samples the modulator bit once every 16 master clocks. A bit of 1 counts as +1 and a bit of 0 counts as -1.
- R2: Timing with chopping off. Let N be the effective decimation factor. A result is produced every N samples, but the first two results after a restart are withheld. The first visible `res_valid` therefore comes 3N samples after the restart, and later ones are exactly 16·N master clocks apart.
- R3: Result value. Take the samples since the last clear (or restart), with zeros assumed before it. The raw result is the convolution of these samples with the cube of an N-long box, a kernel of length 3N-2, evaluated at the latest sample.
- R4: Scaling and clamping. Let c be the smallest integer with 2^c >= N. The raw result is multiplied by 2^(23-3c), rounding toward minus infinity when the exponent is negative. It is then clamped to the range -8388608 to 8388607 and presented as a two's-complement `res_data`. A full-scale positive input gives 8388607.
- R5: Timing with chopping on. After a restart or a clear, one result appears after 3N samples. The filter is then cleared, so later results are exactly 48·N master clocks apart.
- R6: Polarity. `swap_pol` is 0 after a restart. In chop mode it toggles in the same cycle that `res_valid` rises. In non-chop mode it stays 0.
- R7: Pair average. In chop mode, each clamped result taken while `swap_pol` was 1 is negated. The value of `avg_data` is floor((previous corrected + current corrected)/2). `avg_valid` first rises with the second result after a restart and never rises in non-chop mode.
- R8: Restart. A change on `sf_word` or `chop_en` restarts the filter, the settling count and the polarity. A decimation word below 2 acts as 2.
- R9: Strobes. `res_valid` is a single-cycle pulse, and `avg_valid` is only high together with `res_valid`.
- R10: Reset. While reset is held, every output reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mod_bit | input | 1 | Modulator output bit |
| sf_word | input | 12 | Decimation factor |
| chop_en | input | 1 | Chopping mode enable |
| res_data | output | 24 | Latest clamped result, two's complement |
| res_valid | output | 1 | One-cycle strobe for a new result |
| avg_data | output | 24 | Offset-cancelled average of the latest pair |
| avg_valid | output | 1 | One-cycle strobe for a new average |
| swap_pol | output | 1 | Input reversal request to the analog front end |

## Verification
A faulty integrator or a missed clear does not fail at once. It shows up as a wrong `res_data` at the next result strobe, which is one decimation period later, or three periods later in chop mode. After that the error keeps returning, because the integrators never forget it. A wrong settling or sample count moves the `res_valid` strobe off its exact 16·N or 48·N spacing, and this is visible at the first strobe after a restart. A wrong polarity state inverts `swap_pol`, and it also gives `avg_data` the wrong sign at the very next pair. The bench checks all of these against its model on every clock.

// File: rtl/sinc3_pkg.sv
package sinc3_pkg;
  localparam int SF_W  = 12;
  localparam int ORDER = 3;
  localparam int ACC_W = ORDER*SF_W + 1;
  localparam int OUT_W = 24;

  typedef logic signed [ACC_W-1:0] acc_t;
  typedef logic signed [OUT_W-1:0] word_t;
  typedef logic signed [OUT_W:0]   corr_t;

  localparam logic signed [ACC_W:0] POS_LIM = (ACC_W+1)'((64'sd1 <<< (OUT_W-1)) - 64'sd1);
  localparam logic signed [ACC_W:0] NEG_LIM = (ACC_W+1)'(-(64'sd1 <<< (OUT_W-1)));
  localparam word_t POS_MAX = {1'b0, {(OUT_W-1){1'b1}}};
  localparam word_t NEG_MIN = {1'b1, {(OUT_W-1){1'b0}}};

  // decimation word with the floor of two applied
  function automatic logic [SF_W-1:0] eff_sf(input logic [SF_W-1:0] sf);
    return (sf < SF_W'(2)) ? SF_W'(2) : sf;
  endfunction

  // smallest c with 2^c >= n
  function automatic int unsigned ceil_log2(input logic [SF_W-1:0] n);
    int unsigned c;
    c = 0;
    for (int k = 0; k < SF_W; k++)
      if ((32'd1 << k) < 32'(n)) c = k + 1;
    return c;
  endfunction

  // normalise the raw sinc sum to OUT_W bits and clamp at full scale
  function automatic word_t scale_clamp(input acc_t y, input int unsigned c);
    logic signed [ACC_W:0] wide;
    logic signed [ACC_W:0] t;
    int sh;
    wide = {y[ACC_W-1], y};
    sh = ORDER*int'(c) - (OUT_W-1);
    if (sh >= 0) t = wide >>> sh;
    else         t = wide <<< (-sh);
    if (t > POS_LIM)      return POS_MAX;
    else if (t < NEG_LIM) return NEG_MIN;
    else                  return t[OUT_W-1:0];
  endfunction

  // sign correction for the reversed phase, one extra bit of headroom
  function automatic corr_t sign_fix(input word_t v, input logic neg);
    corr_t e;
    e = {v[OUT_W-1], v};
    return neg ? -e : e;
  endfunction

  // floor of the mean of two corrected results
  function automatic word_t pair_mean(input corr_t a, input corr_t b);
    logic signed [OUT_W+1:0] s;
    s = {a[OUT_W], a} + {b[OUT_W], b};
    return s[OUT_W:1];
  endfunction
endpackage

// File: rtl/sinc3_tick_gen.sv
module sinc3_tick_gen #(
  parameter int DIV = 16
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV-1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else                 cnt <= cnt + CW'(1);
  end

  assign tick = (cnt == LAST);

  AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick); // R1
endmodule

// File: rtl/sinc3_core.sv
module sinc3_core import sinc3_pkg::*; (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic            clear,
  input  logic            din,
  input  logic [SF_W-1:0] n_eff,
  output acc_t            y,
  output logic            y_vld
);
  acc_t integ   [ORDER];
  acc_t integ_n [ORDER];
  acc_t dly     [ORDER];
  acc_t comb_v  [ORDER];
  acc_t xs;
  logic [SF_W-1:0] scnt;
  logic            period_end;

  assign xs         = din ? acc_t'(1) : acc_t'(-1);
  assign period_end = (scnt == n_eff - SF_W'(1));

  always_comb begin
    integ_n[0] = integ[0] + xs;
    for (int k = 1; k < ORDER; k++)
      integ_n[k] = integ[k] + integ_n[k-1];
    comb_v[0] = integ_n[ORDER-1] - dly[0];
    for (int k = 1; k < ORDER; k++)
      comb_v[k] = comb_v[k-1] - dly[k];
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      for (int k = 0; k < ORDER; k++) begin
        integ[k] <= '0;
        dly[k]   <= '0;
      end
      scnt  <= '0;
      y     <= '0;
      y_vld <= 1'b0;
    end else begin
      y_vld <= 1'b0;
      if (tick) begin
        for (int k = 0; k < ORDER; k++) integ[k] <= integ_n[k];
        if (period_end) begin
          scnt   <= '0;
          dly[0] <= integ_n[ORDER-1];
          for (int k = 1; k < ORDER; k++) dly[k] <= comb_v[k-1];
          y      <= comb_v[ORDER-1];
          y_vld  <= 1'b1;
        end else begin
          scnt <= scnt + SF_W'(1);
        end
      end
    end
  end

  AST_CORE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    y_vld |=> !y_vld); // R2
  AST_CORE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    y_vld |-> $past(tick)); // R1
  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (integ[0] == '0 && integ[1] == '0 && integ[2] == '0 && !y_vld)); // R5
endmodule

// File: rtl/sinc3_chop_seq.sv
module sinc3_chop_seq import sinc3_pkg::*; (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            restart,
  input  logic            chop,
  input  logic [SF_W-1:0] n_eff,
  input  acc_t            core_y,
  input  logic            core_vld,
  output logic            core_clear,
  output word_t           res_data,
  output logic            res_valid,
  output word_t           avg_data,
  output logic            avg_valid,
  output logic            pol
);
  localparam logic [1:0] SETTLED = 2'd2;

  logic [1:0] ocnt;
  logic       have_prev;
  corr_t      prev_corr;
  word_t      scaled;
  corr_t      cur_corr;
  word_t      mean_w;
  logic       emit;

  assign scaled     = scale_clamp(core_y, ceil_log2(n_eff));
  assign cur_corr   = sign_fix(scaled, pol);
  assign mean_w     = pair_mean(prev_corr, cur_corr);
  assign emit       = core_vld && (ocnt == SETTLED) && !restart;
  assign core_clear = restart || (emit && chop);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ocnt      <= '0;
      have_prev <= 1'b0;
      prev_corr <= '0;
      pol       <= 1'b0;
      res_data  <= '0;
      res_valid <= 1'b0;
      avg_data  <= '0;
      avg_valid <= 1'b0;
    end else if (restart) begin
      ocnt      <= '0;
      have_prev <= 1'b0;
      pol       <= 1'b0;
      res_valid <= 1'b0;
      avg_valid <= 1'b0;
    end else begin
      res_valid <= emit;
      avg_valid <= emit && chop && have_prev;
      if (core_vld) begin
        if (ocnt != SETTLED) ocnt <= ocnt + 2'd1;
        else if (chop)       ocnt <= '0;
      end
      if (emit) begin
        res_data <= scaled;
        if (chop) begin
          prev_corr <= cur_corr;
          have_prev <= 1'b1;
          pol       <= ~pol;
          if (have_prev) avg_data <= mean_w;
        end
      end
    end
  end

  AST_POL_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    (emit && chop) |=> (pol != $past(pol))); // R6
  AST_POL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !chop |-> !pol); // R6
  AST_AVG_WITH_RES: assert property (@(posedge clk) disable iff (!rst_n)
    avg_valid |-> (res_valid && chop)); // R7
  AST_RES_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid); // R9
endmodule

// File: rtl/sinc3_chop_decim.sv
module sinc3_chop_decim import sinc3_pkg::*; #(
  parameter int DIV = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mod_bit,
  input  logic [SF_W-1:0]  sf_word,
  input  logic             chop_en,
  output logic [OUT_W-1:0] res_data,
  output logic             res_valid,
  output logic [OUT_W-1:0] avg_data,
  output logic             avg_valid,
  output logic             swap_pol
);
  logic [SF_W-1:0] cfg_sf;
  logic            cfg_chop;
  logic            restart;
  logic [SF_W-1:0] n_eff;
  logic            tick;
  logic            core_clear;
  acc_t            core_y;
  logic            core_vld;
  word_t           res_w;
  word_t           avg_w;

  assign restart = (sf_word != cfg_sf) || (chop_en != cfg_chop);
  assign n_eff   = eff_sf(cfg_sf);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_sf   <= '0;
      cfg_chop <= 1'b0;
    end else if (restart) begin
      cfg_sf   <= sf_word;
      cfg_chop <= chop_en;
    end
  end

  sinc3_tick_gen #(.DIV(DIV)) u_tick (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick)
  );

  sinc3_core u_core (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick),
    .clear (core_clear),
    .din   (mod_bit),
    .n_eff (n_eff),
    .y     (core_y),
    .y_vld (core_vld)
  );

  sinc3_chop_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .restart    (restart),
    .chop       (cfg_chop),
    .n_eff      (n_eff),
    .core_y     (core_y),
    .core_vld   (core_vld),
    .core_clear (core_clear),
    .res_data   (res_w),
    .res_valid  (res_valid),
    .avg_data   (avg_w),
    .avg_valid  (avg_valid),
    .pol        (swap_pol)
  );

  assign res_data = res_w;
  assign avg_data = avg_w;

  AST_RESTART_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (!res_valid && !swap_pol)); // R8
endmodule

// File: tb/tb_sinc3_chop_decim.sv
`timescale 1ns/1ps
module tb_sinc3_chop_decim;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        mod_bit;
  logic [11:0] sf_word;
  logic        chop_en;
  logic [23:0] res_data;
  logic        res_valid;
  logic [23:0] avg_data;
  logic        avg_valid;
  logic        swap_pol;

  always #2 clk = ~clk;

  sinc3_chop_decim dut (
    .clk(clk), .rst_n(rst_n), .mod_bit(mod_bit), .sf_word(sf_word), .chop_en(chop_en),
    .res_data(res_data), .res_valid(res_valid), .avg_data(avg_data),
    .avg_valid(avg_valid), .swap_pol(swap_pol)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit cmp_on = 0;
  int mode = 0;
  logic [15:0] lfsr = 16'hACE1;
  longint total_cyc = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // stimulus: 0 ones, 1 zeros, 2 pseudo-random, 3 opposite of polarity
  always @(negedge clk) begin
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    case (mode)
      0: mod_bit <= 1'b1;
      1: mod_bit <= 1'b0;
      2: mod_bit <= lfsr[0];
      default: mod_bit <= !swap_pol;
    endcase
  end

  // ---------------- behavioural reference ----------------
  longint hcoef [0:1299];
  longint box2  [0:899];
  int     hist[$];
  int     m_div, m_sf, m_cnt, m_ocnt;
  bit     m_chop, m_pend, m_pol, m_have, m_tick, m_clr;
  longint m_y, m_sc, m_corr, m_prev;
  bit     e_rv, e_av;
  longint e_rd, e_ad;

  function automatic int n_of(input int sf);
    return (sf < 2) ? 2 : sf;
  endfunction

  function automatic void build_h(input int n);
    for (int j = 0; j < 2*n; j++) box2[j] = 0;
    for (int a = 0; a < n; a++)
      for (int b = 0; b < n; b++) box2[a+b] += 1;
    for (int j = 0; j < 3*n; j++) hcoef[j] = 0;
    for (int j = 0; j <= 2*n-2; j++)
      for (int c = 0; c < n; c++) hcoef[j+c] += box2[j];
  endfunction

  function automatic longint conv_ref(input int n);
    longint acc = 0;
    int len = hist.size();
    for (int j = 0; j <= 3*n-3; j++)
      if (len-1-j >= 0) acc += hcoef[j] * hist[len-1-j];
    return acc;
  endfunction

  function automatic longint scale_ref(input longint y, input int n);
    int c = 0;
    int e;
    longint v, d;
    while ((1 << c) < n) c++;
    e = 23 - 3*c;
    if (e >= 0) v = y * (longint'(1) << e);
    else begin
      d = longint'(1) << (-e);
      v = (y >= 0) ? y / d : -((-y + d - 1) / d);
    end
    if (v > 8388607) v = 8388607;
    if (v < -8388608) v = -8388608;
    return v;
  endfunction

  function automatic longint floor_half(input longint s);
    return (s < 0) ? (s - 1) / 2 : s / 2;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_div = 0; m_sf = 0; m_chop = 0; hist.delete(); m_cnt = 0; m_pend = 0;
      m_ocnt = 0; m_pol = 0; m_have = 0; m_prev = 0; m_y = 0;
      e_rv = 0; e_rd = 0; e_av = 0; e_ad = 0;
      build_h(2);
    end else begin
      m_tick = (m_div == 15);
      m_div = (m_div + 1) % 16;
      e_rv = 0; e_av = 0;
      if (int'(sf_word) != m_sf || chop_en != m_chop) begin
        m_sf = int'(sf_word); m_chop = chop_en; hist.delete(); m_cnt = 0; m_pend = 0;
        m_ocnt = 0; m_pol = 0; m_have = 0;
        build_h(n_of(m_sf));
      end else begin
        m_clr = 0;
        if (m_pend) begin
          m_pend = 0;
          if (m_ocnt == 2) begin
            m_sc = scale_ref(m_y, n_of(m_sf));
            e_rv = 1; e_rd = m_sc;
            if (m_chop) begin
              m_corr = m_pol ? -m_sc : m_sc;
              if (m_have) begin e_av = 1; e_ad = floor_half(m_prev + m_corr); end
              m_prev = m_corr; m_have = 1; m_pol = !m_pol; m_ocnt = 0; m_clr = 1;
            end
          end else m_ocnt++;
        end
        if (m_clr) begin
          hist.delete(); m_cnt = 0;
        end else if (m_tick) begin
          hist.push_back(mod_bit ? 1 : -1);
          m_cnt++;
          if (m_cnt == n_of(m_sf)) begin
            m_cnt = 0; m_pend = 1; m_y = conv_ref(n_of(m_sf));
          end
        end
      end
    end
  end

  // every-clock comparison, plus strobe width
  bit prev_rv = 0;
  always @(negedge clk) begin
    if (cmp_on) begin
      chk(res_valid == e_rv, "R2 res_valid", res_valid, e_rv);
      chk(longint'($signed(res_data)) == e_rd, "R3 res_data", longint'($signed(res_data)), e_rd);
      chk(avg_valid == e_av, "R7 avg_valid", avg_valid, e_av);
      chk(longint'($signed(avg_data)) == e_ad, "R7 avg_data", longint'($signed(avg_data)), e_ad);
      chk(swap_pol == m_pol, "R6 swap_pol", swap_pol, m_pol);
      if (prev_rv) chk(!res_valid, "R9 pulse width", res_valid, 0);
      if (avg_valid) chk(res_valid, "R9 avg with res", res_valid, 1);
      prev_rv = res_valid;
    end
  end

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin
    total_cyc++;
    if (total_cyc >= 190000) begin
      chk(0, "R2 watchdog", total_cyc, 190000);
      finish_run();
    end
  end

  task automatic wait_pulse(output int cyc);
    cyc = 0;
    do begin
      @(negedge clk);
      cyc++;
    end while (!res_valid && cyc < 30000);
    if (!res_valid) chk(0, "R2 no strobe", cyc, 0);
  endtask

  task automatic set_cfg(input int sf, input bit ch, input int md);
    sf_word = 12'(sf); chop_en = ch; mode = md;
  endtask

  task automatic first_window(input int n, input string req);
    int cyc;
    wait_pulse(cyc);
    chk(cyc >= (3*n-1)*16 + 3 && cyc <= 3*n*16 + 2, req, cyc, 3*n*16);
  endtask

  int cyc;

  initial begin
    rst_n = 0; sf_word = 12'd16; chop_en = 0; mode = 0;
    repeat (4) @(negedge clk);
    // R10 reset state
    chk(res_valid == 0 && avg_valid == 0 && swap_pol == 0, "R10 strobes", res_valid, 0);
    chk(res_data == 0 && avg_data == 0, "R10 data", res_data, 0);
    rst_n = 1; cmp_on = 1;

    // non-chop, full-scale ones, N=16
    first_window(16, "R2 first result");
    chk(longint'($signed(res_data)) == 8388607, "R4 clamp", longint'($signed(res_data)), 8388607);
    chk(!avg_valid, "R7 no avg non-chop", avg_valid, 0);
    wait_pulse(cyc);
    chk(cyc == 16*16, "R2 spacing", cyc, 256);

    // all zeros: negative full scale fits exactly
    @(negedge clk); mode = 1;
    repeat (3) wait_pulse(cyc);
    chk(longint'($signed(res_data)) == -8388608, "R4 negative scale", longint'($signed(res_data)), -8388608);

    // floor of two
    @(negedge clk); set_cfg(0, 0, 2);
    first_window(2, "R8 floor first");
    wait_pulse(cyc);
    chk(cyc == 32, "R8 floor spacing", cyc, 32);
    wait_pulse(cyc);
    chk(cyc == 32, "R1 sample spacing", cyc, 32);

    // larger factor, right shift path
    @(negedge clk); set_cfg(200, 0, 2);
    first_window(200, "R2 first N=200");
    wait_pulse(cyc);
    chop_en = 0;
    chk(cyc == 3200, "R1 spacing N=200", cyc, 3200);

    // odd factor
    @(negedge clk); set_cfg(37, 0, 2);
    first_window(37, "R2 first N=37");
    repeat (2) wait_pulse(cyc);
    chk(cyc == 592, "R3 spacing N=37", cyc, 592);

    // chop with polarity-following input
    @(negedge clk); set_cfg(16, 1, 3);
    first_window(16, "R5 first chopped");
    chk(swap_pol == 1, "R6 toggled", swap_pol, 1);
    chk(!avg_valid, "R7 no avg on first", avg_valid, 0);
    wait_pulse(cyc);
    chk(cyc == 768, "R5 chop spacing", cyc, 768);
    chk(longint'($signed(res_data)) == -8388608, "R4 reversed phase", longint'($signed(res_data)), -8388608);
    chk(avg_valid && longint'($signed(avg_data)) == 8388607, "R7 clipped pair", longint'($signed(avg_data)), 8388607);
    chk(swap_pol == 0, "R6 toggled back", swap_pol, 0);

    // chop with constant input: offset-like content cancels
    @(negedge clk); set_cfg(16, 1, 0);
    repeat (3) wait_pulse(cyc);
    chk(longint'($signed(avg_data)) == 0, "R7 cancel", longint'($signed(avg_data)), 0);

    // restart while reversed
    chk(swap_pol == 1, "R6 before restart", swap_pol, 1);
    @(negedge clk); sf_word = 12'd20;
    @(negedge clk);
    chk(swap_pol == 0, "R8 polarity reset", swap_pol, 0);
    first_window(20, "R8 settle after restart");

    // chop with floor-of-two factor
    @(negedge clk); set_cfg(1, 1, 2);
    first_window(2, "R8 chop floor first");
    wait_pulse(cyc);
    chk(cyc == 96, "R5 chop spacing N=2", cyc, 96);

    // chop, random, odd factor
    @(negedge clk); set_cfg(37, 1, 2);
    repeat (4) wait_pulse(cyc);
    chk(cyc == 1776, "R5 chop spacing N=37", cyc, 1776);

    repeat (20) @(negedge clk);
    finish_run();
  end
endmodule